// File: doc/BRIEF.md
# Bit-Field Test, Modify, Extract and Scan Unit

This block applies a single bit-field operation to a 32-bit register operand. A field is named by a start offset and a bit count. The offset is counted from the operand's top bit downward. The field may run past bit 0 and continue at bit 31. Every operation first tests the field as it was before the operation. The operation may then rewrite the field bits in the operand, return a register result, or both. The negative and zero flags are set from that test, and the overflow and carry flags are cleared.

An execution stage uses the unit by presenting one operation per cycle with `in_valid` high. One clock later the unit returns the possibly rewritten operand, a register result and the flags, marked by `out_valid`. There is no extend-flag port: the unit never alters extend, so the caller keeps its current value.

Top module: `bfu_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While reset is held, `out_valid`, `out_word`, `out_reg`, `out_n` and `out_z` are zero.
- R2: `in_op` selects one operation: 0 test, 1 clear, 2 set, 3 invert, 4 signed extract, 5 unsigned extract, 6 insert, 7 first-one scan. The field MSB is operand bit 31−offset. Field bit i sits at operand bit 31−((offset+i) mod 32), so the field wraps from bit 0 to bit 31. A width code of 0 means 32 bits.
- R3: For every operation except insert, `out_n` equals the original field MSB and `out_z` is 1 exactly when all original field bits are zero.
- R4: `out_v` and `out_c` are always 0.
- R5: Test, both extracts and scan return `out_word` equal to the input operand.
- R6: Clear, set and invert write zeros, ones or the complement into the field bits only. All operand bits outside the field keep their values.
- R7: Signed extract returns the field right-aligned and sign-extended to 32 bits. Unsigned extract returns it zero-extended.
- R8: Insert places the low `width` bits of `in_src` into the field, with `in_src` bit width−1 at the field MSB. Its `out_n` is `in_src` bit width−1, and its `out_z` is 1 when those low bits are all zero. `out_reg` is 0.
- R9: Scan returns offset plus the index, counted from the field MSB, of the first set field bit. If no field bit is set, it returns offset plus width.
- R10: Test, clear, set and invert return `out_reg` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 3 | Operation select |
| in_word | input | 32 | Register operand |
| in_offset | input | 5 | Field start, counted from bit 31 |
| in_width | input | 5 | Field width, 0 means 32 |
| in_src | input | 32 | Insert source, low bits used |
| out_valid | output | 1 | Result present |
| out_word | output | 32 | Operand after the operation |
| out_reg | output | 32 | Extract or scan result |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag, always 0 |
| out_c | output | 1 | Carry flag, always 0 |

## Verification
Clear, set and invert test the field and rewrite it in the same cycle. The flags must therefore describe the field contents that the returned word no longer holds. The sweep runs every operation over every offset and width code against all-zero, all-one and mixed operands. Clearing a field of ones must give a returned field of zeros together with `out_z` = 0. Setting a zero field must give a field of ones with `out_z` = 1. Wrapped fields stress the same overlap at the bit 0 to bit 31 seam.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
   typedef enum logic [2:0] {
      BF_TEST = 3'd0,
      BF_CLEAR = 3'd1,
      BF_SET = 3'd2,
      BF_FLIP = 3'd3,
      BF_XSGN = 3'd4,
      BF_XUNS = 3'd5,
      BF_PUT = 3'd6,
      BF_SCAN = 3'd7
   } bf_op_e;
endpackage

// File: rtl/bfu_rotate.sv
module bfu_rotate #(
   parameter int DW = 32,
   parameter bit LEFT = 1'b1
) (
   input  logic [DW-1:0]         data_i,
   input  logic [$clog2(DW)-1:0] amt_i,
   output logic [DW-1:0]         data_o
);
   localparam int AW = $clog2(DW);

   logic [DW-1:0] stage [AW+1];
   assign stage[0] = data_i;

   for (genvar k = 0; k < AW; k++) begin : g_stage
      localparam int SH = 1 << k;
      logic [DW-1:0] turned;
      if (LEFT) begin : g_left
         assign turned = {stage[k][DW-1-SH:0], stage[k][DW-1:DW-SH]};
      end else begin : g_right
         assign turned = {stage[k][SH-1:0], stage[k][DW-1:SH]};
      end
      assign stage[k+1] = amt_i[k] ? turned : stage[k];
   end

   assign data_o = stage[AW];
endmodule

// File: rtl/bfu_mask.sv
module bfu_mask #(
   parameter int DW = 32
) (
   input  logic [$clog2(DW)-1:0] code_i,
   output logic [$clog2(DW):0]   len_o,
   output logic [DW-1:0]         low_o,
   output logic [DW-1:0]         top_o
);
   localparam int AW = $clog2(DW);
   localparam int WW = AW + 1;

   assign len_o = (code_i == '0) ? WW'(DW) : {1'b0, code_i};

   for (genvar i = 0; i < DW; i++) begin : g_bit
      assign low_o[i] = (WW'(i) < len_o);
      assign top_o[i] = (WW'(DW - 1 - i) < len_o);
   end
endmodule

// File: rtl/bfu_lzc.sv
module bfu_lzc #(
   parameter int DW = 32
) (
   input  logic [DW-1:0]         data_i,
   output logic [$clog2(DW)-1:0] count_o,
   output logic                  none_o
);
   localparam int AW = $clog2(DW);

   always_comb begin
      count_o = '0;
      for (int i = 0; i < DW; i++) begin
         if (data_i[i]) count_o = AW'(DW - 1 - i);
      end
   end

   assign none_o = (data_i == '0);
endmodule

// File: rtl/bfu_unit.sv
module bfu_unit #(
   parameter int DW = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [2:0]            in_op,
   input  logic [DW-1:0]         in_word,
   input  logic [$clog2(DW)-1:0] in_offset,
   input  logic [$clog2(DW)-1:0] in_width,
   input  logic [DW-1:0]         in_src,
   output logic                  out_valid,
   output logic [DW-1:0]         out_word,
   output logic [DW-1:0]         out_reg,
   output logic                  out_n,
   output logic                  out_z,
   output logic                  out_v,
   output logic                  out_c
);
   import bfu_pkg::*;

   localparam int AW = $clog2(DW);
   localparam int WW = AW + 1;

   if (DW < 8 || (DW & (DW - 1)) != 0) begin : g_bad_dw
      $error("bfu_unit: DW must be a power of two of at least 8");
   end

   bf_op_e op;
   assign op = bf_op_e'(in_op);

   logic [DW-1:0] rot_w, fmask_top, fmask_low, word_mask;
   logic [DW-1:0] fld_hit, repl_top, repl_word, new_word;
   logic [DW-1:0] ins_top, msb_pick, xuns, xsgn, scan_val, reg_val;
   logic [WW-1:0] wlen, rsh;
   logic [AW-1:0] lz;
   logic          fld_zero, fld_msb, ins_zero, ins_msb, flag_n, flag_z;

   // field MSB moved to the top bit
   bfu_rotate #(.DW(DW), .LEFT(1'b1)) u_rot_in (
      .data_i(in_word), .amt_i(in_offset), .data_o(rot_w));

   bfu_mask #(.DW(DW)) u_mask (
      .code_i(in_width), .len_o(wlen), .low_o(fmask_low), .top_o(fmask_top));

   assign rsh      = WW'(DW) - wlen;
   assign fld_hit  = rot_w & fmask_top;
   assign fld_msb  = rot_w[DW-1];
   assign ins_top  = in_src << rsh;
   assign msb_pick = fmask_low & ~(fmask_low >> 1);
   assign ins_msb  = |(in_src & msb_pick);
   assign ins_zero = ((in_src & fmask_low) == '0);

   bfu_lzc #(.DW(DW)) u_lzc (
      .data_i(fld_hit), .count_o(lz), .none_o(fld_zero));

   always_comb begin
      unique case (op)
         BF_CLEAR: repl_top = '0;
         BF_SET:   repl_top = '1;
         BF_FLIP:  repl_top = ~rot_w;
         BF_PUT:   repl_top = ins_top;
         default:  repl_top = rot_w;
      endcase
   end

   // field mask and replacement back to operand positions
   bfu_rotate #(.DW(DW), .LEFT(1'b0)) u_rot_mask (
      .data_i(fmask_top), .amt_i(in_offset), .data_o(word_mask));
   bfu_rotate #(.DW(DW), .LEFT(1'b0)) u_rot_repl (
      .data_i(repl_top), .amt_i(in_offset), .data_o(repl_word));

   assign new_word = (in_word & ~word_mask) | (repl_word & word_mask);

   assign xuns     = rot_w >> rsh;
   assign xsgn     = DW'($signed(rot_w) >>> rsh);
   assign scan_val = DW'(in_offset) + (fld_zero ? DW'(wlen) : DW'(lz));

   always_comb begin
      unique case (op)
         BF_XSGN: reg_val = xsgn;
         BF_XUNS: reg_val = xuns;
         BF_SCAN: reg_val = scan_val;
         default: reg_val = '0;
      endcase
   end

   assign flag_n = (op == BF_PUT) ? ins_msb  : fld_msb;
   assign flag_z = (op == BF_PUT) ? ins_zero : fld_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_word  <= '0;
         out_reg   <= '0;
         out_n     <= 1'b0;
         out_z     <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_word <= new_word;
            out_reg  <= reg_val;
            out_n    <= flag_n;
            out_z    <= flag_z;
         end
      end
   end

   assign out_v = 1'b0;
   assign out_c = 1'b0;

   p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_outside_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((out_word & ~$past(word_mask)) == ($past(in_word) & ~$past(word_mask))));

   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BF_CLEAR) |=> ((out_word & $past(word_mask)) == '0));

   p_set_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BF_SET) |=> ((out_word & $past(word_mask)) == $past(word_mask)));

   p_word_same_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op == BF_TEST || op == BF_XSGN || op == BF_XUNS || op == BF_SCAN))
      |=> (out_word == $past(in_word)));

   p_sext_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BF_XSGN) |=> (out_reg[DW-1] == $past(fld_msb)));

   p_scan_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op == BF_SCAN && fld_zero) |=> out_z);
endmodule

// File: tb/bfu_unit_tb.sv
module bfu_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  in_op = '0;
   logic [31:0] in_word = '0, in_src = '0;
   logic [4:0]  in_offset = '0, in_width = '0;
   logic        out_valid, out_n, out_z, out_v, out_c;
   logic [31:0] out_word, out_reg;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   bfu_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_word(in_word), .in_offset(in_offset), .in_width(in_width),
      .in_src(in_src), .out_valid(out_valid), .out_word(out_word),
      .out_reg(out_reg), .out_n(out_n), .out_z(out_z), .out_v(out_v),
      .out_c(out_c));

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s op=%0d off=%0d wc=%0d actual=%h expected=%h",
                  tag, in_op, in_offset, in_width, act, exp);
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=%0d expected<%0d", cycles, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   // independent bitwise model of the requirements
   task automatic model(input int opc, input logic [31:0] w, input int off, input int wc,
                        input logic [31:0] src, output logic [31:0] ew, output logic [31:0] er,
                        output logic en, output logic ez);
      int wd;
      int p;
      int first;
      logic [63:0] fld;
      wd = (wc == 0) ? 32 : wc;
      fld = '0;
      ew = w;
      first = -1;
      for (int i = 0; i < wd; i++) begin
         p = 31 - ((off + i) % 32);
         fld = (fld << 1) | 64'(w[p]);
         if (w[p] && first < 0) first = i;
         case (opc)
            1: ew[p] = 1'b0;
            2: ew[p] = 1'b1;
            3: ew[p] = ~w[p];
            6: ew[p] = src[wd - 1 - i];
            default: ;
         endcase
      end
      en = fld[wd - 1];
      ez = (fld == 0);
      er = '0;
      case (opc)
         4: er = en ? 32'(fld | (~64'd0 << wd)) : 32'(fld);
         5: er = 32'(fld);
         7: er = (first < 0) ? 32'(off + wd) : 32'(off + first);
         6: begin
            en = src[wd - 1];
            ez = 1'b1;
            for (int i = 0; i < wd; i++) if (src[i]) ez = 1'b0;
         end
         default: ;
      endcase
   endtask

   task automatic run_one(input int opc, input logic [31:0] w, input int off, input int wc,
                          input logic [31:0] src);
      logic [31:0] ew, er;
      logic en, ez;
      string wt, rt, ft;
      @(negedge clk);
      in_valid  = 1'b1;
      in_op     = 3'(opc);
      in_word   = w;
      in_offset = 5'(off);
      in_width  = 5'(wc);
      in_src    = src;
      model(opc, w, off, wc, src, ew, er, en, ez);
      @(negedge clk);
      if (opc == 1 || opc == 2 || opc == 3) wt = "R6 word";
      else if (opc == 6) wt = "R8 word";
      else wt = "R5 word";
      if (opc == 4 || opc == 5) rt = "R7 reg";
      else if (opc == 7) rt = "R9 reg";
      else if (opc == 6) rt = "R8 reg";
      else rt = "R10 reg";
      ft = (opc == 6) ? "R8 flags" : "R3 flags";
      check(wt, 64'(out_word), 64'(ew));
      check(rt, 64'(out_reg), 64'(er));
      check(ft, {62'd0, out_n, out_z}, {62'd0, en, ez});
      check("R4 vc", {62'd0, out_v, out_c}, 64'd0);
      check("R1 valid", 64'(out_valid), 64'd1);
   endtask

   initial begin
      logic [31:0] pat;
      repeat (3) @(negedge clk);
      check("R1 reset valid", 64'(out_valid), 64'd0);
      check("R1 reset word", 64'(out_word), 64'd0);
      check("R1 reset reg", 64'(out_reg), 64'd0);
      check("R1 reset flags", {62'd0, out_n, out_z}, 64'd0);
      rst_n = 1'b1;

      // R2 wrap: offset 30 width 4 covers bits 1,0,31,30
      run_one(2, 32'h0, 30, 4, 32'h0);
      check("R2 wrap set", 64'(out_word), 64'hC000_0003);
      run_one(7, 32'h8000_0000, 30, 4, 32'h0);
      check("R2 wrap scan", 64'(out_reg), 64'd32);

      for (int pk = 0; pk < 4; pk++) begin
         for (int opc = 0; opc < 8; opc++) begin
            for (int off = 0; off < 32; off++) begin
               for (int wc = 0; wc < 32; wc++) begin
                  case (pk)
                     0: pat = 32'h0;
                     1: pat = 32'hFFFF_FFFF;
                     2: pat = 32'hA5C3_1E87;
                     default: pat = 32'h1 << ((off * 7 + wc) % 32);
                  endcase
                  run_one(opc, pat, off, wc, ~pat ^ (32'h9E37_79B9 * 32'(off + wc)));
               end
            end
         end
      end

      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      check("R1 valid drop", 64'(out_valid), 64'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule